// File: doc/BRIEF.md
# Dual-Direction Latch/Register Bus Transceiver

This block moves an 18-bit word in both directions between an A port and a B port. Each direction has one storage element and four controls of its own: an active-low drive enable, a pass-through enable, a capture clock and an active-low capture enable. The storage element can pass data straight through, capture it on a rising edge of the capture clock, or hold it. Data is never inverted. The block has no tri-state pins. Each port is a separate input vector, output vector and per-bit drive-enable vector, and the pad ring turns these into real bus drivers.

The capture clocks are ordinary inputs sampled by the block's system clock. A two-state edge machine (`EDG_LOW`, `EDG_HIGH`) per direction detects their rising edges. Pass-through is a multiplexer in front of the output. While pass-through is on, the storage register reloads on every system clock, so leaving pass-through keeps the last value that was passed.

Edge machine transitions, per direction:
- `EDG_LOW` → `EDG_HIGH` when the sampled capture clock is high. This cycle is a rising edge.
- `EDG_HIGH` → `EDG_LOW` when the sampled capture clock is low.
- Reset puts the machine in `EDG_HIGH`.

Top module: `bxc_transceiver`

## Requirements
- R1: While a direction's pass-through enable is high, its output equals its input in the same cycle, bit for bit and not inverted.
- R2: A rising edge is a system-clock cycle in which the capture clock is sampled high after it was sampled low in the previous cycle. Directly after reset, the previous sample counts as high. In a rising-edge cycle with pass-through low and capture enable low (0), the input is stored at that system clock edge, and the output shows it from the next cycle.
- R3: With pass-through low and no rising edge, the output keeps its value. A capture clock held high for several cycles stores only once.
- R4: With the capture enable high (1), a rising edge does not change the stored value.
- R5: The drive-enable vector is all ones when the drive enable input is 0 and all zeros when it is 1.
- R6: While reset (rst_n = 0) is asserted, both drive-enable vectors are all zeros and both stored values are cleared to zero.
- R7: The two directions are independent. No control or data of one direction affects the other.
- R8: When pass-through goes from high to low, the stored value is the input from the last cycle in which pass-through was high. This holds even if the capture clock is high at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the capture clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 18 | Data received from the A port |
| a_out | output | 18 | Data driven onto the A port |
| a_oe | output | 18 | Per-bit drive enable for the A port |
| b_in | input | 18 | Data received from the B port |
| b_out | output | 18 | Data driven onto the B port |
| b_oe | output | 18 | Per-bit drive enable for the B port |
| ab_oe_n | input | 1 | A-to-B drive enable, active low |
| ab_le | input | 1 | A-to-B pass-through enable |
| ab_cp | input | 1 | A-to-B capture clock |
| ab_ce_n | input | 1 | A-to-B capture enable, active low |
| ba_oe_n | input | 1 | B-to-A drive enable, active low |
| ba_le | input | 1 | B-to-A pass-through enable |
| ba_cp | input | 1 | B-to-A capture clock |
| ba_ce_n | input | 1 | B-to-A capture enable, active low |

## Verification
The assertions are checked on every cycle. They cover:
- the pass-through path;
- the hold of the output when there is no rising edge or the capture enable is high;
- the value stored on a rising edge;
- the value kept when pass-through falls;
- the shape of the drive-enable vectors, in reset and outside it.

Some behaviour only the bench scenarios can show:
- that the two directions are independent;
- that a capture clock held high stores only once;
- that the stored values are cleared by reset, which is seen by reading them back with pass-through low.

// File: rtl/bxc_pkg.sv
package bxc_pkg;

    // Sampled level of a capture clock, as seen by the edge machine.
    typedef enum logic {
        EDG_LOW  = 1'b0,
        EDG_HIGH = 1'b1
    } edg_state_t;

    localparam int unsigned N_DIR  = 2;
    localparam int unsigned DIR_AB = 0;
    localparam int unsigned DIR_BA = 1;

endpackage

// File: rtl/bxc_edge_fsm.sv
module bxc_edge_fsm
    import bxc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cp,
    output logic rise
);

    edg_state_t st_q;
    edg_state_t st_d;

    // State register. Reset assumes the clock was high, so no false edge follows reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= EDG_HIGH;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state and edge output.
    always_comb begin
        st_d = st_q;
        rise = 1'b0;
        unique case (st_q)
            EDG_LOW: begin
                if (cp) begin
                    st_d = EDG_HIGH;
                    rise = 1'b1;
                end
            end
            EDG_HIGH: begin
                if (!cp) begin
                    st_d = EDG_LOW;
                end
            end
            default: st_d = EDG_HIGH;
        endcase
    end

endmodule

// File: rtl/bxc_lane.sv
module bxc_lane #(
    parameter int unsigned DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic              le,
    input  logic              cp,
    input  logic              ce_n,
    input  logic              oe_n,
    output logic [DATA_W-1:0] dout,
    output logic [DATA_W-1:0] doe
);

    logic              cp_rise;
    logic              load;
    logic [DATA_W-1:0] store_q;

    bxc_edge_fsm u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .cp    (cp),
        .rise  (cp_rise)
    );

    // Reload while passing through; otherwise only on an enabled rising edge.
    assign load = le | (cp_rise & ~ce_n);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_q <= '0;
        end else if (load) begin
            store_q <= din;
        end
    end

    assign dout = le ? din : store_q;
    assign doe  = {DATA_W{rst_n & ~oe_n}};

endmodule

// File: rtl/bxc_transceiver.sv
module bxc_transceiver
    import bxc_pkg::*;
#(
    parameter int unsigned DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] a_in,
    output logic [DATA_W-1:0] a_out,
    output logic [DATA_W-1:0] a_oe,
    input  logic [DATA_W-1:0] b_in,
    output logic [DATA_W-1:0] b_out,
    output logic [DATA_W-1:0] b_oe,
    input  logic              ab_oe_n,
    input  logic              ab_le,
    input  logic              ab_cp,
    input  logic              ab_ce_n,
    input  logic              ba_oe_n,
    input  logic              ba_le,
    input  logic              ba_cp,
    input  logic              ba_ce_n
);

    logic [DATA_W-1:0] lane_din  [N_DIR];
    logic [DATA_W-1:0] lane_dout [N_DIR];
    logic [DATA_W-1:0] lane_doe  [N_DIR];
    logic [N_DIR-1:0]  lane_le;
    logic [N_DIR-1:0]  lane_cp;
    logic [N_DIR-1:0]  lane_ce_n;
    logic [N_DIR-1:0]  lane_oe_n;

    assign lane_din[DIR_AB]  = a_in;
    assign lane_din[DIR_BA]  = b_in;
    assign lane_le   = {ba_le,   ab_le};
    assign lane_cp   = {ba_cp,   ab_cp};
    assign lane_ce_n = {ba_ce_n, ab_ce_n};
    assign lane_oe_n = {ba_oe_n, ab_oe_n};

    for (genvar d = 0; d < N_DIR; d++) begin : g_dir
        bxc_lane #(.DATA_W(DATA_W)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (lane_din[d]),
            .le    (lane_le[d]),
            .cp    (lane_cp[d]),
            .ce_n  (lane_ce_n[d]),
            .oe_n  (lane_oe_n[d]),
            .dout  (lane_dout[d]),
            .doe   (lane_doe[d])
        );
    end

    assign b_out = lane_dout[DIR_AB];
    assign b_oe  = lane_doe[DIR_AB];
    assign a_out = lane_dout[DIR_BA];
    assign a_oe  = lane_doe[DIR_BA];

endmodule

// File: rtl/bxc_transceiver_chk.sv
module bxc_transceiver_chk #(
    parameter int unsigned DATA_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] a_in,
    input logic [DATA_W-1:0] a_out,
    input logic [DATA_W-1:0] a_oe,
    input logic [DATA_W-1:0] b_in,
    input logic [DATA_W-1:0] b_out,
    input logic [DATA_W-1:0] b_oe,
    input logic              ab_oe_n,
    input logic              ab_le,
    input logic              ab_cp,
    input logic              ab_ce_n,
    input logic              ba_oe_n,
    input logic              ba_le,
    input logic              ba_cp,
    input logic              ba_ce_n
);

    // R1
    ab_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ab_le |-> (b_out == a_in));
    // R1
    ba_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ba_le |-> (a_out == b_in));

    // R2
    ab_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_le && $past(!ab_le && !ab_ce_n && ab_cp && rst_n)
         && !$past(ab_cp, 2) && $past(rst_n, 2)) |-> (b_out == $past(a_in)));
    // R2
    ba_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ba_le && $past(!ba_le && !ba_ce_n && ba_cp && rst_n)
         && !$past(ba_cp, 2) && $past(rst_n, 2)) |-> (a_out == $past(b_in)));

    // R3
    ab_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_le && $past(!ab_le && rst_n) && !($past(ab_cp) && !$past(ab_cp, 2)))
        |-> $stable(b_out));
    // R3
    ba_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ba_le && $past(!ba_le && rst_n) && !($past(ba_cp) && !$past(ba_cp, 2)))
        |-> $stable(a_out));

    // R4
    ab_ce_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_le && $past(!ab_le && ab_ce_n && rst_n)) |-> $stable(b_out));
    // R4
    ba_ce_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ba_le && $past(!ba_le && ba_ce_n && rst_n)) |-> $stable(a_out));

    // R5
    ab_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_oe_n ? (b_oe == '0) : (b_oe == '1)));
    // R5
    ba_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ba_oe_n ? (a_oe == '0) : (a_oe == '1)));

    // R6
    reset_drive_chk: assert property (@(posedge clk)
        !rst_n |-> ((a_oe == '0) && (b_oe == '0)));

    // R8
    ab_le_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ab_le) && $past(rst_n)) |-> (b_out == $past(a_in)));
    // R8
    ba_le_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ba_le) && $past(rst_n)) |-> (a_out == $past(b_in)));

endmodule

bind bxc_transceiver bxc_transceiver_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_in    (a_in),
    .a_out   (a_out),
    .a_oe    (a_oe),
    .b_in    (b_in),
    .b_out   (b_out),
    .b_oe    (b_oe),
    .ab_oe_n (ab_oe_n),
    .ab_le   (ab_le),
    .ab_cp   (ab_cp),
    .ab_ce_n (ab_ce_n),
    .ba_oe_n (ba_oe_n),
    .ba_le   (ba_le),
    .ba_cp   (ba_cp),
    .ba_ce_n (ba_ce_n)
);

// File: tb/bxc_transceiver_bench.sv
module bxc_transceiver_bench;

    localparam int unsigned W     = 18;
    localparam int          CLK_P = 10;
    localparam int unsigned NRAND = 3000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, a_oe, b_out, b_oe;
    logic ab_oe_n = 1'b1, ab_le = 1'b0, ab_cp = 1'b0, ab_ce_n = 1'b1;
    logic ba_oe_n = 1'b1, ba_le = 1'b0, ba_cp = 1'b0, ba_ce_n = 1'b1;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Bench model of each direction's stored word and previous capture-clock sample.
    logic [W-1:0] mq_ab = '0, mq_ba = '0;
    logic mprev_ab = 1'b1, mprev_ba = 1'b1;
    bit cap_ab = 1'b0, cap_ba = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    bxc_transceiver #(.DATA_W(W)) u_bxc_transceiver (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_cp(ab_cp), .ab_ce_n(ab_ce_n),
        .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_cp(ba_cp), .ba_ce_n(ba_ce_n)
    );

    function automatic logic [W-1:0] exp_out(input logic le, input logic [W-1:0] din,
                                             input logic [W-1:0] q);
        return le ? din : q;
    endfunction

    function automatic logic [W-1:0] exp_oe(input logic rn, input logic oe_n);
        return (rn && !oe_n) ? '1 : '0;
    endfunction

    task automatic cmp(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        string t_ab, t_ba;
        if (!rst_n) begin
            mq_ab = '0; mq_ba = '0; mprev_ab = 1'b1; mprev_ba = 1'b1;
        end
        t_ab = ab_le ? "R1 b_out" : (cap_ab ? "R2 b_out" : "R3 b_out");
        t_ba = ba_le ? "R1 a_out" : (cap_ba ? "R2 a_out" : "R3 a_out");
        cmp(t_ab, b_out, exp_out(ab_le, a_in, mq_ab));
        cmp(t_ba, a_out, exp_out(ba_le, b_in, mq_ba));
        cmp(rst_n ? "R5 b_oe" : "R6 b_oe", b_oe, exp_oe(rst_n, ab_oe_n));
        cmp(rst_n ? "R5 a_oe" : "R6 a_oe", a_oe, exp_oe(rst_n, ba_oe_n));
    endtask

    task automatic model_update();
        cap_ab = 1'b0; cap_ba = 1'b0;
        if (rst_n) begin
            if (ab_le) mq_ab = a_in;
            else if (ab_cp && !mprev_ab && !ab_ce_n) begin mq_ab = a_in; cap_ab = 1'b1; end
            if (ba_le) mq_ba = b_in;
            else if (ba_cp && !mprev_ba && !ba_ce_n) begin mq_ba = b_in; cap_ba = 1'b1; end
            mprev_ab = ab_cp;
            mprev_ba = ba_cp;
        end
    endtask

    // Called just after a falling edge with inputs already applied.
    task automatic tick();
        #2;
        check_all();
        model_update();
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished at %0t", $time);
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_0b1c));
        @(negedge clk);
        // R6: reset state, pass-through low exposes cleared storage
        ab_oe_n = 1'b0; ba_oe_n = 1'b0; a_in = 18'h3ffff; b_in = 18'h2aaaa;
        tick(); tick();
        rst_n = 1'b1; ab_cp = 1'b1; ba_cp = 1'b1;
        tick();
        // R1: pass-through both ways
        ab_le = 1'b1; ba_le = 1'b1; a_in = 18'h12345; b_in = 18'h0f0f0;
        tick();
        a_in = 18'h20001;
        tick();
        // R8: pass-through falls while capture clock is high
        ab_le = 1'b0; ba_le = 1'b0; a_in = 18'h11111; b_in = 18'h22222;
        tick(); tick();
        // R2: capture on rising edge; R3: clock held high stores once
        ab_cp = 1'b0; ab_ce_n = 1'b0;
        tick();
        ab_cp = 1'b1; a_in = 18'h3c3c3;
        tick();
        a_in = 18'h00077;
        tick(); tick();
        // R4: capture enable high blocks the edge
        ab_cp = 1'b0; ab_ce_n = 1'b1;
        tick();
        ab_cp = 1'b1; a_in = 18'h1abcd;
        tick(); tick();
        // R7: activity on B-to-A leaves A-to-B untouched
        ba_ce_n = 1'b0; ba_cp = 1'b0; ba_oe_n = 1'b1;
        tick();
        ba_cp = 1'b1; b_in = 18'h35555;
        tick(); tick();
        // R5: drive enable toggling
        ab_oe_n = 1'b1; ba_oe_n = 1'b0;
        tick();
        // Random phase with biased controls.
        for (int i = 0; i < NRAND; i++) begin
            a_in    = W'($urandom);
            b_in    = W'($urandom);
            ab_le   = ($urandom % 4) == 0;
            ba_le   = ($urandom % 4) == 0;
            ab_cp   = $urandom % 2;
            ba_cp   = $urandom % 2;
            ab_ce_n = ($urandom % 4) == 0;
            ba_ce_n = ($urandom % 4) == 0;
            ab_oe_n = ($urandom % 5) == 0;
            ba_oe_n = ($urandom % 5) == 0;
            rst_n   = ($urandom % 200) != 0;
            tick();
        end
        rst_n = 1'b1;
        tick();
        finish_run();
    end

endmodule